// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a single read or write burst on a synchronous DRAM. A start strobe brings in a 9-bit starting column, a write flag and three fields from a latched copy of the mode register: a length code, an ordering bit and a single-write override bit. On each following clock the block presents one column address with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned group of columns that holds the start column. The order inside that group is either a wrapping increment or the start position XORed with the beat index. A full-page burst steps through the whole 512-column row, wrapping at the top, until a terminate input stops it. If the start request carries an unusable mode combination, the block pulses an error flag and emits no beats. Command timing, latency delays and the memory pins are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: The length code sets the number of valid beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page that runs until terminated.
- R2: With ordering bit 0 and length L of 2, 4 or 8, beat k has address bits above log2(L) equal to those of the start column and low bits equal to (start + k) mod L.
- R3: With ordering bit 1 and length L of 2, 4 or 8, beat k has upper bits equal to the start column's and low bits equal to (start XOR k) mod L.
- R4: A full-page burst (code 3'b111, ordering bit 0) emits start + k mod 512 on beat k, never raises last_o, and drops valid_o on the clock after a cycle in which term_i is sampled high during a beat.
- R5: With length code 3'b000 exactly one beat is emitted at the start column, whatever the ordering bit.
- R6: When wbm_i is 1 and write_i is 1, exactly one beat is emitted at the start column for any valid length code. A read with wbm_i 1, or a write with wbm_i 0, uses the programmed length.
- R7: A start request with length code 3'b100, 3'b101 or 3'b110, or with code 3'b111 and ordering bit 1, raises err_o for one cycle on the clock after it is accepted and emits no valid beat. This check uses the programmed fields even when the single-write override applies.
- R8: The first beat appears on the clock after the accepting edge, one beat follows per clock, and last_o is high only on the final beat of a fixed burst.
- R9: A start request presented during the final beat (last_o high) is accepted, and its first beat follows on the next clock with no idle cycle.
- R10: A start request presented while a burst is running and last_o is low is ignored: the running burst continues unchanged and no further burst follows it.
- R11: After reset valid_o, last_o and err_o are 0 and col_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a burst |
| write_i | input | 1 | The requested burst is a write |
| start_col_i | input | 9 | Starting column address |
| len_code_i | input | 3 | Burst length code from the mode image |
| ilv_i | input | 1 | Ordering bit: 0 increment, 1 XOR |
| wbm_i | input | 1 | Single-location write override |
| term_i | input | 1 | Stops a running full-page burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a fixed burst |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
All outputs are registered. The first beat, or the error pulse, of a request accepted at one rising edge is visible right after that edge, and each later beat follows one edge later. A terminate sampled at an edge clears valid at that same edge, so the beat shown while term_i was high is the final one. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so beat k of a burst is read k+1 falling edges after the strobe was raised, and the idle check falls one edge after the final beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef enum logic {
        ORD_INCR = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             write_i,
    input  logic             wbm_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_page_o,
    output logic             bad_o
);

    logic [COL_W-1:0] prog_mask;
    logic             prog_page;
    logic             reserved;
    logic             single_wr;

    always_comb begin
        prog_mask = '0;
        prog_page = 1'b0;
        reserved  = 1'b0;
        case (len_code_i)
            LEN_ONE:   prog_mask = '0;
            LEN_TWO:   prog_mask = COL_W'(1);
            LEN_FOUR:  prog_mask = COL_W'(3);
            LEN_EIGHT: prog_mask = COL_W'(7);
            LEN_PAGE: begin
                prog_mask = '1;
                prog_page = 1'b1;
            end
            default:   reserved = 1'b1;
        endcase
    end

    assign single_wr   = write_i && wbm_i;
    assign mask_o      = single_wr ? '0 : prog_mask;
    assign full_page_o = prog_page && !single_wr;
    assign bad_o       = reserved || (prog_page && (ilv_i == ORD_XOR));

    initial begin
        assert (COL_W >= 3)
            else $error("column width too small for eight-beat bursts");
    end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] incr_v;
    logic [COL_W-1:0] xor_v;

    assign incr_v = base_i + beat_i;
    assign xor_v  = base_i ^ beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = mask_i[i] ? ((ilv_i == ORD_XOR) ? xor_v[i] : incr_v[i])
                                    : base_i[i];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             wbm_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             page;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] col;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_bad;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] col_nx;
    logic             accept;
    logic             stop_page;

    bcs_mode_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .write_i     (write_i),
        .wbm_i       (wbm_i),
        .mask_o      (dec_mask),
        .full_page_o (dec_page),
        .bad_o       (dec_bad)
    );

    assign beat_nx = st_q.beat + COL_W'(1);

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_nx)
    );

    assign accept    = start_i && (!st_q.valid || st_q.last);
    assign stop_page = st_q.page && term_i;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (accept) begin
            if (dec_bad) begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
                st_d.err   = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.base  = start_col_i;
                st_d.beat  = '0;
                st_d.mask  = dec_mask;
                st_d.ilv   = ilv_i && !dec_page;
                st_d.page  = dec_page;
                st_d.col   = start_col_i;
                st_d.last  = !dec_page && (dec_mask == '0);
            end
        end else if (st_q.valid && !st_q.last && !stop_page) begin
            st_d.beat = beat_nx;
            st_d.col  = col_nx;
            st_d.last = !st_q.page && (beat_nx == st_q.mask);
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;
    assign err_o   = st_q.err;

    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    p_last_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (valid_o && !st_q.page));

    p_term_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.page && term_i) |=> !valid_o);

    p_incr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !st_q.ilv && !stop_page)
        |=> (valid_o && ((col_o & $past(st_q.mask)) ==
                         (($past(col_o) + COL_W'(1)) & $past(st_q.mask)))));

    p_block_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !stop_page)
        |=> ((col_o & ~$past(st_q.mask)) == ($past(col_o) & ~$past(st_q.mask))));

    p_xor_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.ilv)
        |-> (((col_o ^ st_q.base) & st_q.mask) == (st_q.beat & st_q.mask)));

    p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i && !dec_bad) |=> valid_o);

endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       wbm_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       err_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_col_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .write_i     (write_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .wbm_i       (wbm_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .err_o       (err_o)
    );

    // fields: col[20:12] code[11:9] ilv[8] wr[7] wbm[6] count[5:1] err[0]
    localparam int NV = 17;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {9'd13,  3'd3, 1'b0, 1'b0, 1'b0, 5'd8, 1'b0},
        {9'd13,  3'd3, 1'b1, 1'b0, 1'b0, 5'd8, 1'b0},
        {9'd6,   3'd2, 1'b0, 1'b0, 1'b0, 5'd4, 1'b0},
        {9'd7,   3'd2, 1'b1, 1'b0, 1'b0, 5'd4, 1'b0},
        {9'd3,   3'd1, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0},
        {9'd511, 3'd1, 1'b1, 1'b0, 1'b0, 5'd2, 1'b0},
        {9'd200, 3'd0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0},
        {9'd201, 3'd0, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0},
        {9'd100, 3'd3, 1'b0, 1'b1, 1'b1, 5'd1, 1'b0},
        {9'd100, 3'd3, 1'b0, 1'b0, 1'b1, 5'd8, 1'b0},
        {9'd102, 3'd2, 1'b1, 1'b1, 1'b0, 5'd4, 1'b0},
        {9'd300, 3'd7, 1'b0, 1'b1, 1'b1, 5'd1, 1'b0},
        {9'd301, 3'd3, 1'b1, 1'b1, 1'b1, 5'd1, 1'b0},
        {9'd40,  3'd4, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1},
        {9'd40,  3'd5, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1},
        {9'd40,  3'd6, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1},
        {9'd40,  3'd7, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1}
    };

    function automatic logic [8:0] exp_col(input logic [8:0] c, input logic [2:0] code,
                                           input logic il, input logic wr, input logic wb,
                                           input int k);
        logic [8:0] m;
        logic [8:0] kk;
        logic [8:0] lo;
        kk = 9'(k);
        if (wr && wb) return c;
        if (code == 3'd7) return c + kk;
        case (code)
            3'd1:    m = 9'd1;
            3'd2:    m = 9'd3;
            3'd3:    m = 9'd7;
            default: m = 9'd0;
        endcase
        lo = il ? ((c ^ kk) & m) : ((c + kk) & m);
        return (c & ~m) | lo;
    endfunction

    function automatic string vec_tag(input logic [2:0] code, input logic il,
                                      input logic wr, input logic wb, input logic er);
        if (er) return "R7";
        if (wb || wr) return "R6";
        if (code == 3'd0) return "R5";
        if (il) return "R3";
        return "R2";
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic kick(input logic [8:0] c, input logic [2:0] code, input logic il,
                        input logic wr, input logic wb);
        start_i     = 1'b1;
        start_col_i = c;
        len_code_i  = code;
        ilv_i       = il;
        write_i     = wr;
        wbm_i       = wb;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    logic [8:0] vc;
    logic [2:0] vcode;
    logic       vil, vwr, vwb, ver;
    logic [4:0] vcnt;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R11", "valid after reset", int'(valid_o), 0);
        chk("R11", "last after reset", int'(last_o), 0);
        chk("R11", "err after reset", int'(err_o), 0);
        chk("R11", "col after reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            {vc, vcode, vil, vwr, vwb, vcnt, ver} = VEC[v];
            kick(vc, vcode, vil, vwr, vwb);
            if (ver) begin
                chk("R7", "err pulse", int'(err_o), 1);
                chk("R7", "no beat with err", int'(valid_o), 0);
                @(negedge clk);
                chk("R7", "err one cycle", int'(err_o), 0);
                chk("R7", "still no beat", int'(valid_o), 0);
            end else begin
                for (int k = 0; k < int'(vcnt); k++) begin
                    chk("R8", "beat valid", int'(valid_o), 1);
                    chk(vec_tag(vcode, vil, vwr, vwb, ver), "beat column", int'(col_o),
                        int'(exp_col(vc, vcode, vil, vwr, vwb, k)));
                    chk("R8", "last flag", int'(last_o), (k == int'(vcnt) - 1) ? 1 : 0);
                    @(negedge clk);
                end
                chk("R1", "idle after burst length", int'(valid_o), 0);
            end
        end

        // Full page from 509, wraps past 511, stopped by terminate
        kick(9'd509, 3'd7, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 600; k++) begin
            if (k < 4 || k > 595 || (k % 50) == 0) begin
                chk("R4", "page column", int'(col_o), (509 + k) % 512);
                chk("R4", "page valid", int'(valid_o), 1);
                chk("R4", "page no last", int'(last_o), 0);
            end
            if (k == 599) term_i = 1'b1;
            @(negedge clk);
        end
        chk("R4", "valid drops after terminate", int'(valid_o), 0);
        term_i = 1'b0;
        @(negedge clk);

        // Back-to-back: second request on final beat of a four-beat burst
        kick(9'd6, 3'd2, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk("R9", "first burst column", int'(col_o), int'(exp_col(9'd6, 3'd2, 1'b0, 1'b0, 1'b0, k)));
            if (k == 3) begin
                chk("R9", "last on final beat", int'(last_o), 1);
                start_i = 1'b1; start_col_i = 9'd21; len_code_i = 3'd3;
                ilv_i = 1'b1; write_i = 1'b0; wbm_i = 1'b0;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        begin
            int seq_b [8] = '{21, 20, 23, 22, 17, 16, 19, 18};
            for (int k = 0; k < 8; k++) begin
                chk("R9", "second burst valid", int'(valid_o), 1);
                chk("R9", "second burst column", int'(col_o), seq_b[k]);
                @(negedge clk);
            end
        end
        chk("R9", "idle after second burst", int'(valid_o), 0);

        // Request in the middle of a burst is dropped
        kick(9'd13, 3'd3, 1'b0, 1'b0, 1'b0);
        begin
            int seq_a [8] = '{13, 14, 15, 8, 9, 10, 11, 12};
            for (int k = 0; k < 8; k++) begin
                chk("R10", "running burst column", int'(col_o), seq_a[k]);
                chk("R10", "running burst valid", int'(valid_o), 1);
                if (k == 2) begin
                    start_i = 1'b1; start_col_i = 9'd300; len_code_i = 3'd0;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        chk("R10", "no burst from dropped request", int'(valid_o), 0);
        @(negedge clk);
        chk("R10", "still idle", int'(valid_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule